// File: doc/BRIEF.md
# Simultaneous X-Y Sample Sequencer

This block is the control state machine for a converter front end in which one analog-to-digital converter is shared by eight inputs through a multiplexer. Inputs 0 (X) and 1 (Y) each have a dedicated sample-and-hold. A sample pulse freezes both at the same instant, and the two held values are then converted one after the other. The converter itself is modelled only as a busy handshake. The block drives the multiplexer select, the X/Y pair hold, the converter hold and a one-cycle start strobe. It raises a one-cycle host flag at each step and tags every converted word with the channel it came from.

The block has two modes. In pair (sequential) mode, a sample pulse holds both X and Y and flags the host. Each host encode strobe starts one conversion. When each conversion ends and a settling delay has passed, the block switches the multiplexer to the other channel and flags the host again. It releases the pair hold only when Y has finished. In addressed (random) mode, the multiplexer follows a 3-bit address. A sample pulse holds the converter, and it holds the X/Y pair as well only when the address is 0 or 1. The end of the conversion releases everything. Sample pulses are ignored while the input section is disabled. A pulse that arrives while a conversion sequence is still running is dropped and recorded in a sticky overrun bit.

Top module: `xy_pair_sequencer`

## Requirements
- R1: After reset, all outputs are 0, including the select (which points at X, channel 0), the overrun bit and the channel tag.
- R2: In pair mode (rand_mode_i=0), when idle and enabled, a sample pulse sampled at a clock edge raises host_flag_o for exactly one cycle and pair_hold_o from that edge. The select stays at 0 and conv_hold_o stays 0.
- R3: An encode strobe while the block waits for one raises adc_start_o for exactly one cycle and sets conv_hold_o. An encode strobe in any other state has no effect on any output.
- R4: busy falls at the edge where adc_busy_i is first seen low after being high. Exactly SETTLE_CYC cycles after that edge, host_flag_o pulses for one cycle and conv_hold_o returns to 0. In pair mode, bit 0 of the select also toggles at that same edge (X to Y, or Y back to X).
- R5: In pair mode, pair_hold_o stays 1 after the X conversion completes. It falls only at the flag that ends the Y conversion.
- R6: In addressed mode, the select follows rand_chan_i while idle. A sample pulse raises host_flag_o and conv_hold_o. For address 0 or 1 it also raises pair_hold_o. Completion of the conversion clears both holds and leaves the select unchanged.
- R7: In addressed mode with an address from 2 to 7, pair_hold_o is never asserted.
- R8: A sample pulse while in_en_i=0 and idle is ignored: no flag, no hold, and no later encode is accepted.
- R9: chan_tag_o takes bit 0 of the select at the start of each conversion and holds it until the next conversion starts, so it is 0 for X words and 1 for Y words.
- R10: An enabled sample pulse while a sequence is in progress changes no hold, flag or select output. It sets overrun_o, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_pulse_i | input | 1 | Sample clock pulse |
| encode_i | input | 1 | Host encode strobe |
| rand_mode_i | input | 1 | 0 = pair mode, 1 = addressed mode |
| rand_chan_i | input | 3 | Addressed-mode channel |
| in_en_i | input | 1 | Input section enable |
| adc_busy_i | input | 1 | Converter busy |
| mux_sel_o | output | 3 | Multiplexer select |
| pair_hold_o | output | 1 | X/Y sample-and-hold hold control |
| conv_hold_o | output | 1 | Converter sample-and-hold hold control |
| adc_start_o | output | 1 | One-cycle conversion start |
| host_flag_o | output | 1 | One-cycle host flag |
| chan_tag_o | output | 1 | Channel tag of the current word |
| overrun_o | output | 1 | Sticky sample overrun |

## Verification
A wrong state would show up at the ports within one conversion. A flag that arrives a cycle early or late is caught by counting cycles from the busy fall, because every step is measured against SETTLE_CYC. A select or tag that does not alternate, or a pair hold that falls after X instead of after Y, is seen at the flag that follows. A sequence that never returns to idle shows up at the next sample pulse, as a missing flag together with a spurious overrun.

// File: rtl/xyseq_pkg.sv
package xyseq_pkg;
    localparam int CHAN_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_ENC,
        ST_CONV,
        ST_SETTLE
    } xys_state_e;

    typedef struct packed {
        xys_state_e          st;
        logic                mode;
        logic [CHAN_W-1:0]   mux;
        logic                pair_hold;
        logic                conv_hold;
        logic                start;
        logic                flag;
        logic                tag;
        logic                ovr;
    } xys_regs_t;
endpackage

// File: rtl/xyseq_fall.sv
module xyseq_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic fell_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign fell_o = sig_q && !sig_i;
endmodule

// File: rtl/xyseq_settle.sv
module xyseq_settle #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic done_o
);
    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);

    logic             run_d, run_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        if (go_i) begin
            run_d = 1'b1;
            cnt_d = CNT_W'(SETTLE_CYC - 1);
        end else if (run_q) begin
            if (cnt_q == '0) run_d = 1'b0;
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

    assign done_o = run_q && (cnt_q == '0);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !go_i) |=> !done_o); // R4
endmodule

// File: rtl/xy_pair_sequencer.sv
module xy_pair_sequencer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_pulse_i,
    input  logic                        encode_i,
    input  logic                        rand_mode_i,
    input  logic [xyseq_pkg::CHAN_W-1:0] rand_chan_i,
    input  logic                        in_en_i,
    input  logic                        adc_busy_i,
    output logic [xyseq_pkg::CHAN_W-1:0] mux_sel_o,
    output logic                        pair_hold_o,
    output logic                        conv_hold_o,
    output logic                        adc_start_o,
    output logic                        host_flag_o,
    output logic                        chan_tag_o,
    output logic                        overrun_o
);
    import xyseq_pkg::*;

    xys_regs_t r_d, r_q;
    logic      busy_fell, settle_go, settle_done, smp_ok;

    xyseq_fall u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (adc_busy_i),
        .fell_o (busy_fell)
    );

    xyseq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (settle_go),
        .done_o (settle_done)
    );

    assign smp_ok    = smp_pulse_i && in_en_i;
    assign settle_go = (r_q.st == ST_CONV) && busy_fell;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.flag  = 1'b0;
        if (smp_ok && r_q.st != ST_IDLE) r_d.ovr = 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.mux = rand_mode_i ? rand_chan_i : '0;
                if (smp_ok) begin
                    r_d.st        = ST_WAIT_ENC;
                    r_d.mode      = rand_mode_i;
                    r_d.flag      = 1'b1;
                    r_d.pair_hold = rand_mode_i ? (rand_chan_i < CHAN_W'(2)) : 1'b1;
                    r_d.conv_hold = rand_mode_i;
                end
            end
            ST_WAIT_ENC: begin
                if (encode_i) begin
                    r_d.st        = ST_CONV;
                    r_d.start     = 1'b1;
                    r_d.conv_hold = 1'b1;
                    r_d.tag       = r_q.mux[0];
                end
            end
            ST_CONV: begin
                if (busy_fell) r_d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    r_d.flag      = 1'b1;
                    r_d.conv_hold = 1'b0;
                    if (r_q.mode) begin
                        r_d.pair_hold = 1'b0;
                        r_d.st        = ST_IDLE;
                    end else begin
                        r_d.mux    = {{(CHAN_W-1){1'b0}}, ~r_q.mux[0]};
                        if (r_q.mux[0]) begin
                            r_d.pair_hold = 1'b0;
                            r_d.st        = ST_IDLE;
                        end else begin
                            r_d.st = ST_WAIT_ENC;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign mux_sel_o   = r_q.mux;
    assign pair_hold_o = r_q.pair_hold;
    assign conv_hold_o = r_q.conv_hold;
    assign adc_start_o = r_q.start;
    assign host_flag_o = r_q.flag;
    assign chan_tag_o  = r_q.tag;
    assign overrun_o   = r_q.ovr;

    AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_flag_o |=> !host_flag_o); // R2
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o); // R3
    AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> conv_hold_o); // R3
    AST_PAIR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pair_hold_o) |-> host_flag_o); // R5
    AST_RAND_NO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && smp_ok && rand_mode_i && rand_chan_i >= CHAN_W'(2))
        |=> !pair_hold_o); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !in_en_i) |=> !host_flag_o); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o); // R10
endmodule

// File: tb/sim_xy_pair_sequencer.sv
module sim_xy_pair_sequencer;
    localparam int SC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_pulse = 1'b0, encode = 1'b0, rand_mode = 1'b0, in_en = 1'b0, busy = 1'b0;
    logic [2:0] rand_chan = '0;
    logic [2:0] mux_sel;
    logic       pair_hold, conv_hold, adc_start, host_flag, chan_tag, overrun;
    int         n_chk = 0, n_bad = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    xy_pair_sequencer #(.SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_pulse_i(smp_pulse), .encode_i(encode),
        .rand_mode_i(rand_mode), .rand_chan_i(rand_chan), .in_en_i(in_en),
        .adc_busy_i(busy), .mux_sel_o(mux_sel), .pair_hold_o(pair_hold),
        .conv_hold_o(conv_hold), .adc_start_o(adc_start), .host_flag_o(host_flag),
        .chan_tag_o(chan_tag), .overrun_o(overrun)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
                summary();
            end
        end
    end

    task automatic pulse();
        @(negedge clk) smp_pulse = 1'b1;
        @(negedge clk) smp_pulse = 1'b0;
    endtask

    task automatic enc();
        @(negedge clk) encode = 1'b1;
        @(negedge clk) encode = 1'b0;
    endtask

    // holds busy for blen edges, returns cycles from busy release to flag
    task automatic convert(int blen, output int n);
        @(negedge clk) busy = 1'b1;
        chk("R3 start width", adc_start, 0);
        repeat (blen - 1) @(negedge clk);
        @(negedge clk) busy = 1'b0;
        n = 0;
        while (!host_flag && n < 50) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mux", mux_sel, 0);
        chk("R1 holds", {pair_hold, conv_hold}, 0);
        chk("R1 strobes", {adc_start, host_flag}, 0);
        chk("R1 tag/ovr", {chan_tag, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 disabled pulse ignored
        pulse();
        chk("R8 flag", host_flag, 0);
        chk("R8 hold", pair_hold, 0);
        enc();
        chk("R8 encode after", adc_start, 0);
        chk("R8 ovr", overrun, 0);

        in_en = 1'b1;
        for (int bl = 1; bl <= 4; bl++) begin
            pulse();
            chk("R2 flag", host_flag, 1);
            chk("R2 pair hold", pair_hold, 1);
            chk("R2 conv hold", conv_hold, 0);
            chk("R2 mux", mux_sel, 0);
            @(negedge clk);
            chk("R2 flag width", host_flag, 0);
            enc();
            chk("R3 start", adc_start, 1);
            chk("R3 conv hold", conv_hold, 1);
            chk("R9 tag X", chan_tag, 0);
            convert(bl, n);
            chk("R4 X delay", n, SC + 1);
            chk("R4 X mux", mux_sel, 1);
            chk("R4 X conv release", conv_hold, 0);
            chk("R5 pair kept after X", pair_hold, 1);
            if (bl == 4) begin
                pulse();
                chk("R10 no flag", host_flag, 0);
                chk("R10 ovr set", overrun, 1);
                chk("R10 mux kept", mux_sel, 1);
                chk("R10 pair kept", pair_hold, 1);
            end
            enc();
            chk("R9 tag Y", chan_tag, 1);
            convert(bl + 1, n);
            chk("R4 Y delay", n, SC + 1);
            chk("R4 Y mux", mux_sel, 0);
            chk("R5 pair released", pair_hold, 0);
            chk("R9 tag held", chan_tag, 1);
            enc();
            chk("R3 idle encode", {adc_start, conv_hold}, 0);
        end
        chk("R10 sticky", overrun, 1);

        // reset clears overrun, then addressed-mode sweep
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R10 reset clears", overrun, 0);
        rand_mode = 1'b1;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk) rand_chan = 3'(c);
            @(negedge clk);
            chk("R6 mux follows", mux_sel, c);
            pulse();
            chk("R6 flag", host_flag, 1);
            chk("R6 conv hold", conv_hold, 1);
            if (c < 2) chk("R6 pair hold", pair_hold, 1);
            else       chk("R7 pair sample", pair_hold, 0);
            enc();
            chk("R6 start", adc_start, 1);
            convert(2, n);
            chk("R4 rand delay", n, SC + 1);
            chk("R6 release", {pair_hold, conv_hold}, 0);
            chk("R6 mux unchanged", mux_sel, c);
            chk("R9 rand tag", chan_tag, c % 2);
        end
        summary();
    end
endmodule